// File: doc/BRIEF.md
# Two-Level Microprogram Sequencer

This block is the control sequencer of a microprogrammed datapath. Its program lives in two read-only tables. The sequence table holds one entry per microinstruction. Each entry carries a next-address mode, a jump target and a short pointer. The pattern table holds each distinct wide control word exactly once. Microinstructions that share a control pattern point to the same pattern entry, so the total storage is sequence depth × sequence width plus pattern depth × control width. With the default sizes that is 1024 × 21 + 450 × 32 bits, against 1024 × 32 bits for a flat store.

Each cycle, the program counter selects a sequence entry. The entry's pointer is registered and then looks up the wide control word, which drives `ctrl_o`. The sequencing fields select the next program counter from the condition input. A start pulse loads an entry address, for example an opcode's first microinstruction. A halt entry raises `done_o` for one cycle and parks the sequencer until the next start. Both tables come from parameter images. With the defaults, the image of `i` occupies bits `[i*W +: W]`.

Top module: `nanoctl_top`

## Requirements
- R1: While reset is low, `ctrl_o` is all zeros and `done_o` is low. Reset release passes through a two-flop synchroniser. Execution then starts at sequence address 0, and the first control word appears after the third rising edge that follows the release.
- R2: A sequence entry has the mode in bits [20:19], the jump target in bits [18:9] and the pattern pointer in bits [8:0]. `ctrl_o` shows the pattern entry named by the pointer of the address that was current one cycle earlier.
- R3: Mode 0 (step) moves to the next address. Address 1023 wraps to 0.
- R4: Mode 1 (jump) moves to the target address.
- R5: Mode 2 (branch) moves to the target when `cond_i` is high and to the next address when it is low.
- R6: Mode 3 (halt) raises `done_o` for one cycle, together with that entry's control word, and holds the program counter. After that, `ctrl_o` stays zero and `done_o` stays low until a start.
- R7: A start pulse loads `entry_i` into the program counter and resumes execution, overriding the mode of the current entry. The entry at the current address still reaches the outputs.
- R8: A pointer at or above the pattern depth (450) yields an all-zero control word.
- R9: Pulling reset low in mid-program clears `ctrl_o` and `done_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load `entry_i` into the program counter and run |
| entry_i | input | 10 | Entry address for a start |
| cond_i | input | 1 | Branch condition for mode 2 |
| ctrl_o | output | 32 | Wide control word for the datapath |
| done_o | output | 1 | One-cycle pulse when a halt entry issues |

## Verification
The program runs under several patterns:
- **Plain step-and-halt from address 0.** Distinguishes the pipeline latency from the latency of the reset synchroniser.
- **A branch taken and not taken, and a jump back into a shared tail.** Separates mode decoding from condition use.
- **A run through address 1023.** Exposes a faulty wrap.
- **A restart in mid-program and a pointer beyond the pattern depth.** Show start priority and out-of-range masking.
- **An asynchronous reset in mid-run.** Checks that the outputs clear at once.

A behavioural model of the program counter is compared with the block on every clock, so any wrong address shows up as a wrong control word.

// File: rtl/nanoctl_pkg.sv
package nanoctl_pkg;

  localparam int DEF_CTRL_W      = 32;
  localparam int DEF_PATTERN_CNT = 450;
  localparam int DEF_SEQ_DEPTH   = 1024;
  localparam int MODE_W          = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_STEP   = 2'd0,
    MODE_JUMP   = 2'd1,
    MODE_BRANCH = 2'd2,
    MODE_HALT   = 2'd3
  } seq_mode_e;

endpackage

// File: rtl/nanoctl_rst_sync.sv
module nanoctl_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;

endmodule

// File: rtl/nanoctl_seq.sv
module nanoctl_seq
  import nanoctl_pkg::*;
#(
  parameter int SEQ_DEPTH = DEF_SEQ_DEPTH,
  parameter int AW        = $clog2(SEQ_DEPTH),
  parameter int IW        = 9,
  parameter int SW        = MODE_W + AW + IW,
  parameter logic [SEQ_DEPTH*SW-1:0] SEQ_IMAGE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   entry_i,
  input  logic            cond_i,
  output logic [AW-1:0]   pc_o,
  output logic            run_o,
  output seq_mode_e       mode_o,
  output logic [AW-1:0]   target_o,
  output logic [IW-1:0]   ptr_o
);

  localparam int TGT_LO  = IW;
  localparam int MODE_LO = IW + AW;

  logic [AW-1:0] pc_q, pc_d;
  logic          run_q, run_d;
  logic          pc_en;
  logic [SW-1:0] word;
  seq_mode_e     mode;
  logic [AW-1:0] target;
  logic [AW-1:0] pc_inc;

  // read the sequence entry at the current address
  always_comb begin
    word   = SEQ_IMAGE[int'(pc_q)*SW +: SW];
    mode   = seq_mode_e'(word[MODE_LO +: MODE_W]);
    target = word[TGT_LO +: AW];
    pc_inc = pc_q + AW'(1);
  end

  // next-address selection
  always_comb begin
    pc_d  = pc_q;
    run_d = run_q;
    pc_en = 1'b0;
    if (start_i) begin
      pc_d  = entry_i;
      run_d = 1'b1;
      pc_en = 1'b1;
    end else if (run_q) begin
      unique case (mode)
        MODE_STEP: begin
          pc_d  = pc_inc;
          pc_en = 1'b1;
        end
        MODE_JUMP: begin
          pc_d  = target;
          pc_en = 1'b1;
        end
        MODE_BRANCH: begin
          pc_d  = cond_i ? target : pc_inc;
          pc_en = 1'b1;
        end
        MODE_HALT: begin
          run_d = 1'b0;
        end
        default: begin
          run_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      run_q <= 1'b1;
    end else begin
      if (pc_en) begin
        pc_q <= pc_d;
      end
      run_q <= run_d;
    end
  end

  assign pc_o     = pc_q;
  assign run_o    = run_q;
  assign mode_o   = mode;
  assign target_o = target;
  assign ptr_o    = word[IW-1:0];

endmodule

// File: rtl/nanoctl_out.sv
module nanoctl_out
  import nanoctl_pkg::*;
#(
  parameter int CTRL_W      = DEF_CTRL_W,
  parameter int PATTERN_CNT = DEF_PATTERN_CNT,
  parameter int IW          = $clog2(PATTERN_CNT),
  parameter logic [PATTERN_CNT*CTRL_W-1:0] PATTERN_IMAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              halt_i,
  input  logic [IW-1:0]     ptr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o
);

  logic [IW-1:0] ptr_q;
  logic          vld_q;
  logic          done_q;
  logic          ptr_en;
  logic          in_range;
  logic [IW-1:0] safe_ptr;

  assign ptr_en = issue_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ptr_en) begin
        ptr_q <= ptr_i;
      end
      vld_q  <= issue_i;
      done_q <= issue_i & halt_i;
    end
  end

  // pattern table lookup, masked when idle or out of range
  always_comb begin
    in_range = (int'(ptr_q) < PATTERN_CNT);
    safe_ptr = in_range ? ptr_q : '0;
    ctrl_o   = '0;
    if (vld_q && in_range) begin
      ctrl_o = PATTERN_IMAGE[int'(safe_ptr)*CTRL_W +: CTRL_W];
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/nanoctl_top.sv
module nanoctl_top
  import nanoctl_pkg::*;
#(
  parameter int CTRL_W      = DEF_CTRL_W,
  parameter int PATTERN_CNT = DEF_PATTERN_CNT,
  parameter int SEQ_DEPTH   = DEF_SEQ_DEPTH,
  parameter logic [SEQ_DEPTH*(MODE_W+$clog2(SEQ_DEPTH)+$clog2(PATTERN_CNT))-1:0]
                  SEQ_IMAGE = '0,
  parameter logic [PATTERN_CNT*CTRL_W-1:0] PATTERN_IMAGE = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [$clog2(SEQ_DEPTH)-1:0] entry_i,
  input  logic                         cond_i,
  output logic [CTRL_W-1:0]            ctrl_o,
  output logic                         done_o
);

  localparam int AW = $clog2(SEQ_DEPTH);
  localparam int IW = $clog2(PATTERN_CNT);
  localparam int SW = MODE_W + AW + IW;

  logic          rst_sync_n;
  logic [AW-1:0] pc;
  logic          run;
  seq_mode_e     mode;
  logic [AW-1:0] target;
  logic [IW-1:0] ptr;

  nanoctl_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  nanoctl_seq #(
    .SEQ_DEPTH (SEQ_DEPTH),
    .AW        (AW),
    .IW        (IW),
    .SW        (SW),
    .SEQ_IMAGE (SEQ_IMAGE)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (start_i),
    .entry_i  (entry_i),
    .cond_i   (cond_i),
    .pc_o     (pc),
    .run_o    (run),
    .mode_o   (mode),
    .target_o (target),
    .ptr_o    (ptr)
  );

  nanoctl_out #(
    .CTRL_W        (CTRL_W),
    .PATTERN_CNT   (PATTERN_CNT),
    .IW            (IW),
    .PATTERN_IMAGE (PATTERN_IMAGE)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .issue_i (run),
    .halt_i  (mode == MODE_HALT),
    .ptr_i   (ptr),
    .ctrl_o  (ctrl_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/nanoctl_chk.sv
module nanoctl_chk #(
  parameter int AW     = 10,
  parameter int CTRL_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [AW-1:0]     entry_i,
  input logic              cond_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              done_o,
  input logic [AW-1:0]     pc,
  input logic              run,
  input logic [1:0]        mode,
  input logic [AW-1:0]     target
);

  // R3
  step_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !start_i && mode == 2'd0 |=> pc == $past(pc) + AW'(1));

  // R4
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !start_i && mode == 2'd1 |=> pc == $past(target));

  // R5
  branch_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !start_i && mode == 2'd2 && cond_i |=> pc == $past(target));

  // R5
  branch_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !start_i && mode == 2'd2 && !cond_i |=> pc == $past(pc) + AW'(1));

  // R6
  halt_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !start_i && mode == 2'd3 |=> !run && done_o && $stable(pc));

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !start_i |=> ctrl_o == '0 && !done_o);

  // R7
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run && pc == $past(entry_i));

endmodule

bind nanoctl_top nanoctl_chk #(.AW(AW), .CTRL_W(CTRL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .start_i (start_i),
  .entry_i (entry_i),
  .cond_i  (cond_i),
  .ctrl_o  (ctrl_o),
  .done_o  (done_o),
  .pc      (pc),
  .run     (run),
  .mode    (mode),
  .target  (target)
);

// File: tb/nanoctl_top_bench.sv
module nanoctl_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 32;
  localparam int NPAT = 450;
  localparam int SEQ  = 1024;
  localparam int SW   = 21;

  function automatic logic [SW-1:0] ent(int m, int tgt, int p);
    return {2'(m), 10'(tgt), 9'(p)};
  endfunction

  function automatic logic [CW-1:0] pat(int i);
    return {~16'(i), 16'(i) ^ 16'h5A3C};
  endfunction

  function automatic logic [SEQ*SW-1:0] build_seq();
    logic [SEQ*SW-1:0] img;
    img = '0;
    img[0*SW +: SW]    = ent(0, 0, 1);
    img[1*SW +: SW]    = ent(0, 0, 2);
    img[2*SW +: SW]    = ent(3, 0, 3);
    img[16*SW +: SW]   = ent(0, 0, 10);
    img[17*SW +: SW]   = ent(2, 20, 11);
    img[18*SW +: SW]   = ent(0, 0, 12);
    img[19*SW +: SW]   = ent(3, 0, 13);
    img[20*SW +: SW]   = ent(1, 18, 14);
    img[40*SW +: SW]   = ent(1, 45, 449);
    img[45*SW +: SW]   = ent(3, 0, 460);
    img[1022*SW +: SW] = ent(0, 0, 5);
    img[1023*SW +: SW] = ent(0, 0, 6);
    return img;
  endfunction

  function automatic logic [NPAT*CW-1:0] build_pat();
    logic [NPAT*CW-1:0] img;
    for (int i = 0; i < NPAT; i++) img[i*CW +: CW] = pat(i);
    return img;
  endfunction

  localparam logic [SEQ*SW-1:0]  SIMG = build_seq();
  localparam logic [NPAT*CW-1:0] PIMG = build_pat();

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [9:0]    entry;
  logic          cond;
  logic [CW-1:0] ctrl;
  logic          done;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase  = "R1";
  logic  comparing = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nanoctl_top #(
    .SEQ_IMAGE     (SIMG),
    .PATTERN_IMAGE (PIMG)
  ) u_nanoctl_top (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .entry_i (entry),
    .cond_i  (cond),
    .ctrl_o  (ctrl),
    .done_o  (done)
  );

  // behavioural reference
  int          m_pc, m_ptr, m_cnt;
  logic        m_run, m_vld, m_done;
  logic [SW-1:0] w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pc <= 0; m_run <= 1'b1;
      m_vld <= 1'b0; m_ptr <= 0; m_done <= 1'b0;
    end else if (m_cnt < 2) begin
      m_cnt <= m_cnt + 1;
    end else begin
      w = SIMG[m_pc*SW +: SW];
      m_vld  <= m_run;
      if (m_run) m_ptr <= int'(w[8:0]);
      m_done <= m_run && (w[20:19] == 2'd3);
      if (start) begin
        m_pc <= int'(entry); m_run <= 1'b1;
      end else if (m_run) begin
        case (w[20:19])
          2'd0: m_pc <= (m_pc + 1) % SEQ;
          2'd1: m_pc <= int'(w[18:9]);
          2'd2: m_pc <= cond ? int'(w[18:9]) : (m_pc + 1) % SEQ;
          default: m_run <= 1'b0;
        endcase
      end
    end
  end

  function automatic logic [CW-1:0] exp_ctrl();
    if (m_vld && m_ptr < NPAT) return PIMG[m_ptr*CW +: CW];
    return '0;
  endfunction

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (comparing) begin
      check({phase, " ctrl"}, ctrl, exp_ctrl());
      check({phase, " done"}, CW'(done), CW'(m_done));
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(int addr, logic c);
    @(negedge clk);
    start = 1'b1; entry = 10'(addr); cond = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; entry = '0; cond = 1'b0;
    idle(3);
    // R1 reset state
    check("R1 ctrl", ctrl, '0);
    check("R1 done", CW'(done), '0);
    comparing = 1'b1;
    phase = "R2";
    rst_n = 1'b1;
    idle(3);
    // R1 first word appears after the third edge after release
    check("R1 first", ctrl, pat(1));
    idle(6);
    phase = "R6"; idle(4);
    phase = "R5"; go(16, 1'b0); idle(8);
    phase = "R4"; go(16, 1'b1); idle(10);
    phase = "R3"; go(1022, 1'b0); idle(10);
    phase = "R8"; go(40, 1'b0); idle(6);
    phase = "R7"; go(16, 1'b0); idle(1); go(40, 1'b0); idle(6);
    phase = "R9"; go(16, 1'b0); idle(1);
    #2 rst_n = 1'b0;
    #1;
    check("R9 ctrl", ctrl, '0);
    check("R9 done", CW'(done), '0);
    idle(2);
    rst_n = 1'b1;
    phase = "R2";
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule